// File: doc/BRIEF.md
# Prioritised Interrupt Vector Arbiter

This block sits between a CPU and the interrupt flags that peripherals raise. Each cycle it looks at every flag together with the enables that apply to it and picks the most urgent request. It then presents one request line to the CPU along with the 16-bit address of the handler's vector word. There are sixteen vector slots, each one word wide, at 0FFE0h through 0FFFEh. A slot with a larger number wins. A slot's vector address is 0FFE0h plus twice its number.

Sources fall into three masking classes. A reset request always wins, and no enable can block it. The system-fault group is gated only by its own per-source enables; the global enable has no effect on it. Every other source needs both its own enable and the global enable. Some slots are shared by several flags. The CPU must clear the flags of a shared slot itself. For a slot fed by exactly one flag, the arbiter gives that source a one-cycle acknowledge when the CPU takes the request. From the moment the CPU takes a request, the vector address is frozen until the CPU lets go of its acknowledge.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `irq_o`=0, `vec_o`=16'hFFE0 and `ack_o`=0.
- R2: A reset request (`rst_req_i`) raises `irq_o` with `vec_o`=16'hFFFE (slot 15), whatever the enables and the global enable are, and beats every other source.
- R3: System-fault flags `nmi_flag_i[2:0]` share slot 14 (16'hFFFC). A flag requests only when its bit in `nmi_en_i` is set, and `gie_i` has no effect on this group.
- R4: A flag in `mask_flag_i` requests only when both its bit in `mask_en_i` and `gie_i` are 1.
- R5: Maskable sources map by index to slots as follows: index 0 goes to slot 11 (16'hFFF6), index 1 to slot 10 (16'hFFF4), index 2 to slot 9 (16'hFFF2), indices 3..5 to slot 8 (16'hFFF0), indices 6..13 to slot 3 (16'hFFE6), and indices 14..21 to slot 2 (16'hFFE4). When several slots are pending, `vec_o` shows the highest one. With nothing pending, `irq_o`=0 and `vec_o`=16'hFFE0.
- R6: `irq_o` and `vec_o` are registered. They reflect the inputs sampled at the previous clock edge, and a change in the inputs does not show before that edge.
- R7: A clock edge at which `cpu_ack_i`=1 and `irq_o`=1 counts as taking the request. From then on `vec_o` holds its value until the first edge at which `cpu_ack_i` is sampled low. After that edge it tracks the inputs again.
- R8: When the request is taken and the slot has exactly one source (slots 9, 10, 11), the `ack_o` bit of that source is 1 for exactly one cycle after the edge. Shared slots and slots 14 and 15 produce no acknowledge.
- R9: Slots 0, 1, 4..7, 12 and 13 have no sources and never appear on `vec_o` while `irq_o`=1.
- R10: `cpu_ack_i` sampled while `irq_o`=0 takes nothing: `vec_o` keeps tracking the inputs and `ack_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req_i | input | 1 | Reset-class request, slot 15 |
| nmi_flag_i | input | 3 | System-fault flags, slot 14 |
| nmi_en_i | input | 3 | Per-source enables of the system-fault flags |
| mask_flag_i | input | 22 | Maskable source flags |
| mask_en_i | input | 22 | Per-source enables of the maskable flags |
| gie_i | input | 1 | Global enable for the maskable class |
| cpu_ack_i | input | 1 | CPU takes the current request while high |
| irq_o | output | 1 | Request to the CPU |
| vec_o | output | 16 | Vector word address of the selected slot |
| ack_o | output | 22 | One-cycle acknowledge per single-source maskable flag |

## Verification
The bench goes through every combination of reset request, global enable, fault flags and fault enables, and every maskable source alone under both enables. It then compares random mixes against an independent priority model. A design that let the global enable gate the fault group, or let an individual enable block the reset request, would show the wrong vector or a missing request. Take sequences raise a reset request while the vector is held, so a design that re-arbitrates early would show 0FFFEh too soon. These sequences also count acknowledge pulses for single and shared slots: a pulse on a shared slot, or one lasting two cycles, would show up. A take attempted with no request pending checks that the vector does not freeze on a stale value.

// File: rtl/ivarb_pkg.sv
// Shared constants and the source-to-slot map of the interrupt vector arbiter.
// Assumes sixteen one-word vector slots; slot numbers double as priorities.
package ivarb_pkg;
    localparam int NUM_SLOTS  = 16;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int VEC_W      = 16;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'hFFE0;
    localparam int SLOT_RESET = 15;
    localparam int SLOT_FAULT = 14;
    localparam int NMI_SRCS   = 3;
    localparam int MASK_SRCS  = 22;

    typedef logic [SLOT_W-1:0] slot_t;

    // Slot served by maskable source idx (-1 for none).
    function automatic int mask_slot(input int idx);
        if (idx == 0)       return 11;
        else if (idx == 1)  return 10;
        else if (idx == 2)  return 9;
        else if (idx < 6)   return 8;
        else if (idx < 14)  return 3;
        else if (idx < 22)  return 2;
        return -1;
    endfunction

    // Number of maskable sources that feed slot s.
    function automatic int slot_fanin(input int s);
        int n;
        n = 0;
        for (int i = 0; i < MASK_SRCS; i++)
            if (mask_slot(i) == s) n++;
        return n;
    endfunction
endpackage

// File: rtl/ivarb_qualify.sv
// Applies the three masking classes and folds qualified flags into one
// pending bit per slot. Purely combinational; assumes flags are already
// synchronous to the arbiter clock.
module ivarb_qualify
    import ivarb_pkg::*;
#(
    parameter int NMI_N  = NMI_SRCS,
    parameter int MASK_N = MASK_SRCS,
    parameter int NSLOT  = NUM_SLOTS
) (
    input  logic              rst_req,
    input  logic [NMI_N-1:0]  nmi_flag,
    input  logic [NMI_N-1:0]  nmi_en,
    input  logic [MASK_N-1:0] mask_flag,
    input  logic [MASK_N-1:0] mask_en,
    input  logic              gie,
    output logic [NSLOT-1:0]  pend
);
    logic [MASK_N-1:0] live;

    // Maskable flags need their own enable and the global enable.
    always_comb live = mask_flag & mask_en & {MASK_N{gie}};

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s == SLOT_RESET) begin : g_rst
            // Reset class: no enable of any kind applies.
            always_comb pend[s] = rst_req;
        end else if (s == SLOT_FAULT) begin : g_fault
            // Fault class: individual enables only.
            always_comb pend[s] = |(nmi_flag & nmi_en);
        end else begin : g_mask
            // OR together every qualified source mapped to this slot.
            always_comb begin
                pend[s] = 1'b0;
                for (int i = 0; i < MASK_N; i++)
                    if (mask_slot(i) == s) pend[s] = pend[s] | live[i];
            end
        end
    end
endmodule

// File: rtl/ivarb_prio.sv
// Fixed-priority encoder: the highest numbered pending slot wins.
// Returns slot 0 when nothing is pending.
module ivarb_prio
    import ivarb_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS
) (
    input  logic [NSLOT-1:0] pend,
    output logic             any,
    output slot_t            best
);
    // Scan upward so the last hit is the highest slot.
    always_comb begin
        best = '0;
        for (int s = 0; s < NSLOT; s++)
            if (pend[s]) best = SLOT_W'(s);
    end

    // Any slot pending at all.
    always_comb any = |pend;
endmodule

// File: rtl/ivarb_hold.sv
// Output registers and take handshake. It tracks the winning slot each
// cycle, freezes it while the CPU holds its acknowledge, and pulses the
// acknowledge of a single-source slot on the take edge. Assumes the CPU
// keeps cpu_ack high for at least one cycle per take.
module ivarb_hold
    import ivarb_pkg::*;
#(
    parameter int MASK_N = MASK_SRCS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_any,
    input  slot_t             best,
    input  logic              cpu_ack,
    output logic              irq_q,
    output slot_t             slot_q,
    output logic              hold_q,
    output logic [MASK_N-1:0] ack_q
);
    logic              take;
    logic [MASK_N-1:0] ack_hit;

    // A take needs a visible request and no take already in progress.
    always_comb take = !hold_q && cpu_ack && irq_q;

    for (genvar i = 0; i < MASK_N; i++) begin : g_ack
        localparam int  S      = mask_slot(i);
        localparam bit  SINGLE = (S >= 0) && (slot_fanin(S) == 1);
        if (SINGLE) begin : g_single
            // Acknowledge this source when its private slot is taken.
            always_comb ack_hit[i] = take && (slot_q == SLOT_W'(S));
        end else begin : g_shared
            // Shared slots leave flag clearing to the handler.
            always_comb ack_hit[i] = 1'b0;
        end
    end

    // Request line follows the pending set every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend_any;
    end

    // Selected slot tracks the winner except while a take is held.
    always_ff @(posedge clk) begin
        if (!rst_n)                slot_q <= '0;
        else if (!hold_q && !take) slot_q <= best;
    end

    // Hold state: set on a take, cleared when cpu_ack is sampled low.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hold_q <= 1'b0;
        else if (take)              hold_q <= 1'b1;
        else if (hold_q && !cpu_ack) hold_q <= 1'b0;
    end

    // One-cycle acknowledge register.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= ack_hit;
    end
endmodule

// File: rtl/irq_vector_arbiter.sv
// Top of the prioritised interrupt vector arbiter: qualifies flags by
// class, picks the highest slot, registers request and vector, and runs
// the take handshake. Assumes all inputs are synchronous to clk.
module irq_vector_arbiter
    import ivarb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rst_req_i,
    input  logic [NMI_SRCS-1:0]  nmi_flag_i,
    input  logic [NMI_SRCS-1:0]  nmi_en_i,
    input  logic [MASK_SRCS-1:0] mask_flag_i,
    input  logic [MASK_SRCS-1:0] mask_en_i,
    input  logic                 gie_i,
    input  logic                 cpu_ack_i,
    output logic                 irq_o,
    output logic [VEC_W-1:0]     vec_o,
    output logic [MASK_SRCS-1:0] ack_o
);
    logic [NUM_SLOTS-1:0] pend;
    logic                 pend_any;
    slot_t                best;
    slot_t                slot_q;
    logic                 hold_q;

    ivarb_qualify #(
        .NMI_N (NMI_SRCS),
        .MASK_N(MASK_SRCS),
        .NSLOT (NUM_SLOTS)
    ) u_qualify (
        .rst_req  (rst_req_i),
        .nmi_flag (nmi_flag_i),
        .nmi_en   (nmi_en_i),
        .mask_flag(mask_flag_i),
        .mask_en  (mask_en_i),
        .gie      (gie_i),
        .pend     (pend)
    );

    ivarb_prio #(
        .NSLOT(NUM_SLOTS)
    ) u_prio (
        .pend(pend),
        .any (pend_any),
        .best(best)
    );

    ivarb_hold #(
        .MASK_N(MASK_SRCS)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_any(pend_any),
        .best    (best),
        .cpu_ack (cpu_ack_i),
        .irq_q   (irq_o),
        .slot_q  (slot_q),
        .hold_q  (hold_q),
        .ack_q   (ack_o)
    );

    // Slot number to word address in the vector block.
    always_comb vec_o = VEC_BASE + {{(VEC_W-SLOT_W-1){1'b0}}, slot_q, 1'b0};
endmodule

// File: rtl/irq_vector_arbiter_chk.sv
// Property checker for the interrupt vector arbiter, bound to the top.
module irq_vector_arbiter_chk
    import ivarb_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rst_req_i,
    input logic                 cpu_ack_i,
    input logic                 irq_o,
    input logic [VEC_W-1:0]     vec_o,
    input logic [MASK_SRCS-1:0] ack_o,
    input logic                 hold_q
);
    assert_reset_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_i && !hold_q && !cpu_ack_i) |=> (irq_o && vec_o == 16'hFFFE));

    assert_vec_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> $stable(vec_o));

    assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    assert_ack_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |=> (ack_o == '0));

    assert_ack_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_o) |-> ($past(cpu_ack_i) && hold_q));

    assert_no_empty_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !(vec_o inside {16'hFFE0, 16'hFFE2, 16'hFFE8, 16'hFFEA,
                                  16'hFFEC, 16'hFFEE, 16'hFFF8, 16'hFFFA}));
endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req_i(rst_req_i),
    .cpu_ack_i(cpu_ack_i),
    .irq_o    (irq_o),
    .vec_o    (vec_o),
    .ack_o    (ack_o),
    .hold_q   (hold_q)
);

// File: tb/irq_vector_arbiter_bench.sv
module irq_vector_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rst_req_i;
    logic [2:0]  nmi_flag_i, nmi_en_i;
    logic [21:0] mask_flag_i, mask_en_i;
    logic        gie_i, cpu_ack_i;
    logic        irq_o;
    logic [15:0] vec_o;
    logic [21:0] ack_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    irq_vector_arbiter u_irq_vector_arbiter (
        .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i),
        .nmi_flag_i(nmi_flag_i), .nmi_en_i(nmi_en_i),
        .mask_flag_i(mask_flag_i), .mask_en_i(mask_en_i),
        .gie_i(gie_i), .cpu_ack_i(cpu_ack_i),
        .irq_o(irq_o), .vec_o(vec_o), .ack_o(ack_o)
    );

    function automatic int src_slot(input int i);
        case (1'b1)
            i == 0: return 11;
            i == 1: return 10;
            i == 2: return 9;
            i <= 5: return 8;
            i <= 13: return 3;
            default: return 2;
        endcase
    endfunction

    // Independent model of the winning slot, -1 when none.
    function automatic int model_slot();
        int b;
        if (rst_req_i) return 15;
        if ((nmi_flag_i & nmi_en_i) != 0) return 14;
        if (!gie_i) return -1;
        b = -1;
        for (int i = 0; i < 22; i++)
            if (mask_flag_i[i] && mask_en_i[i] && src_slot(i) > b) b = src_slot(i);
        return b;
    endfunction

    function automatic logic [15:0] addr_of(input int s);
        return (s < 0) ? 16'hFFE0 : 16'hFFE0 + 16'(2 * s);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic clear_inputs();
        rst_req_i = 0; nmi_flag_i = 0; nmi_en_i = 0;
        mask_flag_i = 0; mask_en_i = 0; gie_i = 0; cpu_ack_i = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Inputs already applied; clock once and compare with the model.
    task automatic step_check(input string tag);
        int s;
        s = model_slot();
        tick();
        check({tag, " irq"}, 32'(irq_o), 32'(s >= 0));
        check({tag, " vec"}, 32'(vec_o), 32'(addr_of(s)));
    endtask

    // Take sequence on one maskable source; reset request arrives mid-hold.
    task automatic take_seq(input int src, input bit single);
        logic [15:0] v;
        clear_inputs();
        tick(); tick();
        mask_flag_i[src] = 1; mask_en_i[src] = 1; gie_i = 1;
        tick();
        v = addr_of(src_slot(src));
        check("R5 vec before take", 32'(vec_o), 32'(v));
        cpu_ack_i = 1;
        tick();
        check("R8 ack on take", 32'(ack_o), single ? 32'(22'(1) << src) : 32'h0);
        rst_req_i = 1;
        tick();
        check("R8 ack single cycle", 32'(ack_o), 32'h0);
        check("R7 vec frozen", 32'(vec_o), 32'(v));
        tick();
        check("R7 vec frozen late", 32'(vec_o), 32'(v));
        cpu_ack_i = 0;
        tick();
        check("R7 vec on release edge", 32'(vec_o), 32'(v));
        tick();
        check("R7 vec tracks after release", 32'(vec_o), 32'hFFFE);
        clear_inputs();
        tick(); tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        rst_req_i = 1; gie_i = 1; mask_flag_i = '1; mask_en_i = '1; cpu_ack_i = 1;
        tick(); tick(); tick();
        check("R1 irq in reset", 32'(irq_o), 32'h0);
        check("R1 vec in reset", 32'(vec_o), 32'hFFE0);
        check("R1 ack in reset", 32'(ack_o), 32'h0);
        clear_inputs();
        rst_n = 1;
        tick();
        check("R5 idle irq", 32'(irq_o), 32'h0);
        check("R5 idle vec", 32'(vec_o), 32'hFFE0);

        // R2/R3: every reset, global enable, fault flag and enable combination.
        for (int c = 0; c < 256; c++) begin
            clear_inputs();
            rst_req_i = c[0]; gie_i = c[1];
            nmi_flag_i = 3'(c >> 2); nmi_en_i = 3'(c >> 5);
            mask_flag_i = '1; mask_en_i = '1;
            step_check(rst_req_i ? "R2 sweep" : "R3 sweep");
        end

        // R4/R5: each maskable source alone under both enables.
        for (int i = 0; i < 22; i++)
            for (int c = 0; c < 4; c++) begin
                clear_inputs();
                mask_flag_i[i] = 1; mask_en_i[i] = c[0]; gie_i = c[1];
                step_check("R4 R5 single source");
            end

        // R6: the change does not show before the edge.
        clear_inputs();
        tick();
        mask_flag_i[0] = 1; mask_en_i[0] = 1; gie_i = 1;
        #1;
        check("R6 no early irq", 32'(irq_o), 32'h0);
        tick();
        check("R6 irq after edge", 32'(irq_o), 32'h1);

        // R5/R9: random mixes against the model.
        for (int k = 0; k < 2000; k++) begin
            clear_inputs();
            rst_req_i  = ($urandom % 16) == 0;
            nmi_flag_i = 3'($urandom);
            nmi_en_i   = (($urandom % 4) == 0) ? 3'($urandom) : 3'b0;
            mask_flag_i = 22'($urandom);
            mask_en_i   = 22'($urandom);
            gie_i = 1'($urandom);
            step_check("R5 random");
            if (irq_o) begin
                int sl;
                sl = int'((vec_o - 16'hFFE0) >> 1);
                check("R9 no empty slot", 32'(sl inside {0, 1, 4, 5, 6, 7, 12, 13}), 32'h0);
            end
        end

        // R7/R8: take sequences on single and shared slots.
        take_seq(0, 1);
        take_seq(1, 1);
        take_seq(2, 1);
        take_seq(4, 0);
        take_seq(10, 0);
        take_seq(17, 0);

        // R10: acknowledge with no request pending does not freeze.
        clear_inputs();
        tick(); tick();
        cpu_ack_i = 1;
        mask_flag_i[1] = 1; mask_en_i[1] = 1; gie_i = 1;
        tick();
        check("R10 vec tracks", 32'(vec_o), 32'hFFF4);
        check("R10 no ack", 32'(ack_o), 32'h0);
        tick();
        check("R10 later take acks", 32'(ack_o), 32'h2);
        clear_inputs();
        tick(); tick();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule